// File: doc/BRIEF.md
# Power Mode Sequencing Controller

This block is the digital sequencer of a multi-rail power unit. When the power-on input rises it first switches on the two always-on regulators: the 1.8 V analog rail and the digital core rail. Once both are up it brings up the two switching converters, one after the other. Peripheral regulators that are selected at start-up join the second converter. The controller holds the processor in reset until the converter outputs report good and a programmable hold time has passed. It drives a "supplies good" flag, and it chooses the source for an external memory supply.

After power-on the high-power request is masked for a fixed settle time, which models oscillator start and bias. During that window the request reads as asserted. Afterwards the request selects between running and sleep. In sleep the converters switch off, the always-on rails stay up, and the peripheral rails stay up unless two sleep-off bits are both set. The memory supply takes the converter in running mode and the always-on analog rail in sleep. A changeover between the two sources always passes through one cycle with no source connected. A shipping bit or a low memory-enable input grounds the memory supply.

A small set of registers is written through a strobe, address and data port. An active-low software reset restores the enable and sleep registers. It leaves the hold-time and shipping registers (1Eh and 1Fh) untouched.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While `pwr_on` is low, all rail enables are 0 and `mem_sel` is 2'b00 (ground), in the same cycle.
- R2: Both always-on enables rise on the first clock edge that samples `pwr_on` high. They then stay high through sleep and through software reset until `pwr_on` falls.
- R3: For SETTLE_CYC cycles after the always-on rails come up, `hp_req` is ignored and read as 1. After that it takes effect, and a low `hp_req` turns the converters off.
- R4: `conv1_en` rises one edge after the always-on rails are up while high power is in effect, and `conv2_en` rises one edge after `conv1_en`. Both fall on the first edge at which high power is no longer in effect.
- R5: Peripheral rail i switches on in the same cycle as `conv2_en` first rises if bit i of register 04h is set (default PER_BOOT). A rail whose bit is clear stays off until the bit is written to 1, and it then turns on two edges after the write strobe.
- R6: In sleep, all peripheral rails go off only when bit 0 (pair-off) and bit 1 (single-off) of register 05h are both 1. Otherwise they keep their running state.
- R7: `proc_rst_n` is low from power-on until `conv2_en`, `conv1_good` and `conv2_good` have been sampled high on HOLD+1 consecutive edges, where HOLD is register 1Eh (default HOLD_DEF). It is then released. It is low in any cycle where `batt_low` is 1.
- R8: `supplies_ok` is 1 only while both converters are enabled, both good flags are 1, `batt_low` is 0 and high power is in effect (outside the settle window, this means `hp_req` is 1).
- R9: `mem_sel` encodes 2'b00 ground, 2'b01 switching converter, 2'b10 always-on analog rail, and never 2'b11. Its target is ground when shipping bit 0 of register 1Fh is 1 or `mem_en` is 0. Otherwise the target is the converter while `conv2_en` is high, and the analog rail otherwise. `mem_sel` follows its target one edge later.
- R10: `mem_sel` never goes directly between 2'b01 and 2'b10; each such change spends exactly one cycle at 2'b00.
- R11: A cycle with `sw_rst_n` low restores register 04h to PER_BOOT and register 05h to 0, and keeps registers 1Eh and 1Fh. A write to any other address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset of all state |
| pwr_on | input | 1 | Power-on request; low shuts everything down |
| hp_req | input | 1 | High-power request (low selects sleep) |
| sw_rst_n | input | 1 | Active-low software reset of control registers |
| batt_low | input | 1 | Battery below minimum level |
| conv1_good | input | 1 | First converter output in range |
| conv2_good | input | 1 | Second converter output in range |
| mem_en | input | 1 | Memory supply enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write address |
| wr_data | input | DW | Register write data |
| aon_ana_en | output | 1 | Always-on analog 1.8 V regulator enable |
| aon_dig_en | output | 1 | Always-on digital core regulator enable |
| conv1_en | output | 1 | First switching converter enable |
| conv2_en | output | 1 | Second switching converter enable |
| per_en | output | N_PER | Peripheral regulator enables |
| proc_rst_n | output | 1 | Active-low processor reset |
| supplies_ok | output | 1 | Converter supplies good |
| mem_sel | output | 2 | Memory supply source select |

## Verification
The assertions check these relations on every cycle:
- Shutdown while power-on is low.
- Always-on rails stay up after power-on.
- Converters and peripheral rails appear only behind the always-on rails, and the first converter leads the second.
- Battery-low forces reset and clears supplies-good.
- The memory select never shows an illegal code or a direct source-to-source change.

Some behaviours involve counts or register contents, and only the bench's scenarios show them:
- The exact settle window, the staggered start-up cycles and the hold-time release.
- The sleep-off bit combinations, and the preservation of 1Eh and 1Fh across software reset.
- The ignored writes, and the one-cycle gap at each memory changeover.

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl #(
  parameter int SETTLE_CYC = 8,
  parameter int N_PER = 3,
  parameter int AW = 5,
  parameter int DW = 8,
  parameter logic [N_PER-1:0] PER_BOOT = 3'b011,
  parameter logic [DW-1:0] HOLD_DEF = 8'd4,
  parameter logic [AW-1:0] ADDR_PEN = 5'h04,
  parameter logic [AW-1:0] ADDR_SLP = 5'h05,
  parameter logic [AW-1:0] ADDR_HOLD = 5'h1E,
  parameter logic [AW-1:0] ADDR_SHIP = 5'h1F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_on,
  input  logic             hp_req,
  input  logic             sw_rst_n,
  input  logic             batt_low,
  input  logic             conv1_good,
  input  logic             conv2_good,
  input  logic             mem_en,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  output logic             aon_ana_en,
  output logic             aon_dig_en,
  output logic             conv1_en,
  output logic             conv2_en,
  output logic [N_PER-1:0] per_en,
  output logic             proc_rst_n,
  output logic             supplies_ok,
  output logic [1:0]       mem_sel
);

  localparam int CW = (SETTLE_CYC < 1) ? 1 : $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] SETTLE_END = CW'(SETTLE_CYC);
  localparam logic [1:0] MEM_GND  = 2'd0;
  localparam logic [1:0] MEM_CONV = 2'd1;
  localparam logic [1:0] MEM_AON  = 2'd2;

  logic             aon_q, c1_q, c2_q, started_q, rel_q, ship_q;
  logic [CW-1:0]    cnt_q;
  logic [N_PER-1:0] per_q, pen_q;
  logic [1:0]       slp_q, mem_q, mem_tgt, mem_nxt;
  logic [DW-1:0]    hcnt_q, hold_q;

  wire settled   = (cnt_q == SETTLE_END);
  wire hp_eff    = settled ? hp_req : 1'b1;
  wire go        = c1_q & hp_eff;
  wire sleep_cut = ~hp_eff & slp_q[0] & slp_q[1];
  wire rails_ok  = c2_q & conv1_good & conv2_good;

  always_comb begin
    if (ship_q || !mem_en) mem_tgt = MEM_GND;
    else if (c2_q)         mem_tgt = MEM_CONV;
    else if (aon_q)        mem_tgt = MEM_AON;
    else                   mem_tgt = MEM_GND;
    if (mem_q != MEM_GND && mem_tgt != MEM_GND && mem_tgt != mem_q)
      mem_nxt = MEM_GND;
    else
      mem_nxt = mem_tgt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || !pwr_on) begin
      aon_q     <= 1'b0;
      cnt_q     <= '0;
      c1_q      <= 1'b0;
      c2_q      <= 1'b0;
      started_q <= 1'b0;
      per_q     <= '0;
      rel_q     <= 1'b0;
      hcnt_q    <= '0;
      mem_q     <= MEM_GND;
    end else begin
      aon_q     <= 1'b1;
      if (aon_q && !settled) cnt_q <= cnt_q + 1'b1;
      c1_q      <= aon_q & hp_eff;
      c2_q      <= go;
      started_q <= started_q | go;
      per_q     <= ((started_q | go) && !sleep_cut) ? pen_q : '0;
      if (!rel_q) begin
        if (!rails_ok)             hcnt_q <= '0;
        else if (hcnt_q == hold_q) rel_q  <= 1'b1;
        else                       hcnt_q <= hcnt_q + 1'b1;
      end
      mem_q     <= mem_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pen_q  <= PER_BOOT;
      slp_q  <= '0;
      hold_q <= HOLD_DEF;
      ship_q <= 1'b0;
    end else begin
      if (!sw_rst_n) begin
        pen_q <= PER_BOOT;
        slp_q <= '0;
      end else if (wr_en && wr_addr == ADDR_PEN) begin
        pen_q <= wr_data[N_PER-1:0];
      end else if (wr_en && wr_addr == ADDR_SLP) begin
        slp_q <= wr_data[1:0];
      end
      if (wr_en && wr_addr == ADDR_HOLD) hold_q <= wr_data;
      if (wr_en && wr_addr == ADDR_SHIP) ship_q <= wr_data[0];
    end
  end

  assign aon_ana_en  = pwr_on & aon_q;
  assign aon_dig_en  = pwr_on & aon_q;
  assign conv1_en    = pwr_on & c1_q;
  assign conv2_en    = pwr_on & c2_q;
  assign per_en      = pwr_on ? per_q : '0;
  assign proc_rst_n  = pwr_on & rel_q & ~batt_low;
  assign supplies_ok = pwr_on & c1_q & c2_q & conv1_good & conv2_good & ~batt_low & hp_eff;
  assign mem_sel     = pwr_on ? mem_q : MEM_GND;

endmodule

// File: rtl/pwr_seq_ctrl_chk.sv
module pwr_seq_ctrl_chk #(
  parameter int N_PER = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwr_on,
  input logic             batt_low,
  input logic             conv1_good,
  input logic             conv2_good,
  input logic             mem_en,
  input logic             aon_ana_en,
  input logic             aon_dig_en,
  input logic             conv1_en,
  input logic             conv2_en,
  input logic [N_PER-1:0] per_en,
  input logic             proc_rst_n,
  input logic             supplies_ok,
  input logic [1:0]       mem_sel
);

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |-> (!aon_ana_en && !aon_dig_en && !conv1_en && !conv2_en && per_en == '0 && mem_sel == 2'b00));

  assert_aon_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(pwr_on) && pwr_on) |-> (aon_ana_en && aon_dig_en));

  assert_conv_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (conv1_en || conv2_en) |-> (aon_ana_en && aon_dig_en));

  assert_conv_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $rose(conv2_en)) |-> conv1_en);

  assert_per_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (per_en != '0) |-> (aon_ana_en && aon_dig_en));

  assert_rst_batt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    batt_low |-> !proc_rst_n);

  assert_ok_R8: assert property (@(posedge clk) disable iff (!rst_n)
    supplies_ok |-> (conv1_en && conv2_en && conv1_good && conv2_good && !batt_low));

  assert_mem_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_sel != 2'b11);

  assert_mem_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(mem_en)) |-> (mem_sel == 2'b00));

  assert_bbm_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(mem_sel) != 2'b00 && mem_sel != 2'b00) |-> (mem_sel == $past(mem_sel)));

endmodule

bind pwr_seq_ctrl pwr_seq_ctrl_chk #(.N_PER(N_PER)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .batt_low(batt_low),
  .conv1_good(conv1_good), .conv2_good(conv2_good), .mem_en(mem_en),
  .aon_ana_en(aon_ana_en), .aon_dig_en(aon_dig_en), .conv1_en(conv1_en),
  .conv2_en(conv2_en), .per_en(per_en), .proc_rst_n(proc_rst_n),
  .supplies_ok(supplies_ok), .mem_sel(mem_sel)
);

// File: tb/pwr_seq_ctrl_tb.sv
module pwr_seq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE = 8;
  localparam int BOOT = 3;
  localparam int HOLD0 = 4;

  logic clk = 1'b0, rst_n = 1'b0, pwr_on = 1'b0, hp_req = 1'b1, sw_rst_n = 1'b1;
  logic batt_low = 1'b0, conv1_good = 1'b0, conv2_good = 1'b0, mem_en = 1'b1, wr_en = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic aon_ana_en, aon_dig_en, conv1_en, conv2_en, proc_rst_n, supplies_ok;
  logic [2:0] per_en;
  logic [1:0] mem_sel;

  pwr_seq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .hp_req(hp_req), .sw_rst_n(sw_rst_n),
    .batt_low(batt_low), .conv1_good(conv1_good), .conv2_good(conv2_good), .mem_en(mem_en),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .aon_ana_en(aon_ana_en), .aon_dig_en(aon_dig_en), .conv1_en(conv1_en), .conv2_en(conv2_en),
    .per_en(per_en), .proc_rst_n(proc_rst_n), .supplies_ok(supplies_ok), .mem_sel(mem_sel)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_err = 0;
  bit running = 0, done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model state
  int m_aon, m_cnt, m_c1, m_c2, m_st, m_per, m_rel, m_hcnt, m_mem;
  int r_pen, r_slp, r_hold, r_ship;

  function automatic int hp_now();
    return (m_cnt >= SETTLE) ? int'(hp_req) : 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_aon = 0; m_cnt = 0; m_c1 = 0; m_c2 = 0; m_st = 0; m_per = 0;
      m_rel = 0; m_hcnt = 0; m_mem = 0;
      r_pen = BOOT; r_slp = 0; r_hold = HOLD0; r_ship = 0;
    end else begin
      int hp, go, tgt, cut, n_pen, n_slp;
      n_pen = r_pen; n_slp = r_slp;
      if (!sw_rst_n) begin n_pen = BOOT; n_slp = 0; end
      else if (wr_en && wr_addr == 5'h04) n_pen = int'(wr_data) % 8;
      else if (wr_en && wr_addr == 5'h05) n_slp = int'(wr_data) % 4;
      if (!pwr_on) begin
        m_aon = 0; m_cnt = 0; m_c1 = 0; m_c2 = 0; m_st = 0; m_per = 0;
        m_rel = 0; m_hcnt = 0; m_mem = 0;
      end else begin
        hp = hp_now();
        go = m_c1 && hp;
        cut = (!hp && r_slp == 3);
        if (r_ship != 0 || !mem_en) tgt = 0;
        else if (m_c2 != 0) tgt = 1;
        else if (m_aon != 0) tgt = 2;
        else tgt = 0;
        if (m_rel == 0) begin
          if (m_c2 != 0 && conv1_good && conv2_good) begin
            if (m_hcnt == r_hold) m_rel = 1; else m_hcnt++;
          end else m_hcnt = 0;
        end
        m_per = ((m_st != 0 || go != 0) && !cut) ? r_pen : 0;
        m_st = (m_st != 0 || go != 0) ? 1 : 0;
        if (m_aon != 0 && m_cnt < SETTLE) m_cnt++;
        m_c2 = go;
        m_c1 = (m_aon != 0 && hp != 0) ? 1 : 0;
        m_aon = 1;
        m_mem = (m_mem != 0 && tgt != 0 && tgt != m_mem) ? 0 : tgt;
      end
      r_pen = n_pen; r_slp = n_slp;
      if (wr_en && wr_addr == 5'h1E) r_hold = int'(wr_data);
      if (wr_en && wr_addr == 5'h1F) r_ship = int'(wr_data) % 2;
    end
  end

  int prev_mem = 0;
  always @(negedge clk) begin
    if (running) begin
      #2;
      begin
        int on, ok;
        on = pwr_on ? 1 : 0;
        ok = (on && m_c1 && m_c2 && conv1_good && conv2_good && !batt_low && hp_now()) ? 1 : 0;
        chk("R2 aon_ana_en", int'(aon_ana_en), on & m_aon);
        chk("R2 aon_dig_en", int'(aon_dig_en), on & m_aon);
        chk("R4 conv1_en", int'(conv1_en), on & m_c1);
        chk("R4 conv2_en", int'(conv2_en), on & m_c2);
        chk("R5/R6 per_en", int'(per_en), on ? m_per : 0);
        chk("R7 proc_rst_n", int'(proc_rst_n), (on && m_rel && !batt_low) ? 1 : 0);
        chk("R8 supplies_ok", int'(supplies_ok), ok);
        chk("R9 mem_sel", int'(mem_sel), on ? m_mem : 0);
        chk("R10 no direct swap", (prev_mem != 0 && mem_sel != 0 && int'(mem_sel) != prev_mem) ? 1 : 0, 0);
        prev_mem = int'(mem_sel);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    cyc(3); rst_n = 1'b1; running = 1;
    cyc(2); #3;
    chk("R1 off aon", int'(aon_ana_en), 0);
    chk("R1 off mem", int'(mem_sel), 0);
    // power on with high-power request low: masked during settle (R3)
    @(negedge clk); pwr_on = 1'b1; hp_req = 1'b0;
    cyc(4); #3;
    chk("R3 conv1 on while masked", int'(conv1_en), 1);
    chk("R5 boot rails", int'(per_en), BOOT);
    cyc(12); #3;
    chk("R3 conv1 off after settle", int'(conv1_en), 0);
    chk("R6 rails kept in sleep", int'(per_en), BOOT);
    chk("R9 mem aon in sleep", int'(mem_sel), 2);
    // run
    @(negedge clk); hp_req = 1'b1; conv1_good = 1'b1; conv2_good = 1'b1;
    cyc(20); #3;
    chk("R7 released", int'(proc_rst_n), 1);
    chk("R8 ok", int'(supplies_ok), 1);
    chk("R9 mem conv", int'(mem_sel), 1);
    @(negedge clk); batt_low = 1'b1;
    #3;
    chk("R7 batt low reset", int'(proc_rst_n), 0);
    chk("R8 batt low", int'(supplies_ok), 0);
    @(negedge clk); batt_low = 1'b0;
    cyc(2);
    // sleep: memory changeover
    @(negedge clk); hp_req = 1'b0;
    cyc(1); #3; chk("R10 step0", int'(mem_sel), 1);
    cyc(1); #3; chk("R10 gap", int'(mem_sel), 0);
    cyc(1); #3; chk("R10 aon", int'(mem_sel), 2);
    chk("R2 aon in sleep", int'(aon_dig_en), 1);
    chk("R4 conv off in sleep", int'(conv2_en), 0);
    wr(5'h05, 8'h03); cyc(1); #3;
    chk("R6 both bits off", int'(per_en), 0);
    wr(5'h05, 8'h01); cyc(1); #3;
    chk("R6 one bit keeps", int'(per_en), BOOT);
    @(negedge clk); hp_req = 1'b1;
    cyc(4);
    wr(5'h04, 8'h07); cyc(1); #3;
    chk("R5 enable via register", int'(per_en), 7);
    wr(5'h10, 8'h00); cyc(1); #3;
    chk("R11 other address ignored", int'(per_en), 7);
    wr(5'h1F, 8'h01); wr(5'h1E, 8'h02); cyc(1); #3;
    chk("R9 shipping grounds", int'(mem_sel), 0);
    @(negedge clk); sw_rst_n = 1'b0;
    @(negedge clk); sw_rst_n = 1'b1;
    cyc(1); #3;
    chk("R11 pen default", int'(per_en), BOOT);
    chk("R11 ship kept", int'(mem_sel), 0);
    chk("R2 aon through sw reset", int'(aon_ana_en), 1);
    wr(5'h1F, 8'h00); cyc(4); #3;
    chk("R9 mem conv again", int'(mem_sel), 1);
    @(negedge clk); mem_en = 1'b0;
    cyc(2); #3;
    chk("R9 mem_en low", int'(mem_sel), 0);
    @(negedge clk); mem_en = 1'b1;
    cyc(3);
    @(negedge clk); pwr_on = 1'b0;
    #3;
    chk("R1 off conv", int'(conv1_en), 0);
    chk("R1 off per", int'(per_en), 0);
    chk("R1 off mem", int'(mem_sel), 0);
    cyc(3);
    @(negedge clk); pwr_on = 1'b1;
    cyc(30); #3;
    chk("R7 release with kept hold", int'(proc_rst_n), 1);
    done = 1;
    running = 0;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule